// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one compare channel that sits beside a timer counter. Each clock it compares the counter value it is given against an active compare register, and from that comparison and a selected mode it builds an internal reference level. The reference then passes through a polarity stage and an output gate to become the channel pin. The channel also sets a sticky flag whenever the counter equals the active compare value.

The compare value can be written straight into the active register. It can also be held in a shadow register and moved across only on the timer's update pulse, so a PWM duty change never lands in the middle of a period. An external clear input, when enabled, holds the reference off until the next update pulse. It does this only in the comparing modes, not in the two forced modes.

Top module: `oc_channel`

## Requirements
- R1: Mode code 0 (frozen): the reference keeps its value and a match does not change it.
- R2: Mode code 1 drives the reference to 1 on a match. Mode code 2 drives it to 0 on a match. Without a match, both modes hold the reference.
- R3: Mode code 3 inverts the reference on every cycle in which the counter equals the active compare value.
- R4: Mode code 4 forces the reference to 0 and mode code 5 forces it to 1, whatever the counter holds.
- R5: In mode code 6 the reference is 1 while the counter is below the active compare value and 0 otherwise. Mode code 7 gives the inverse.
- R6: While clear is enabled, a high clear input makes the reference read as inactive from the next cycle on, until an update pulse arrives with the clear input low. In modes 4 and 5 the clear has no effect on the output. With clear disabled, the clear input is ignored.
- R7: `ch_out` equals the reference XOR `polarity` (1 = active low) when `out_en` is 1, and is 0 when `out_en` is 0.
- R8: With `preload_en` at 1, a write lands in the shadow register only. The shadow register moves into the active compare register at the edge where `update` is 1.
- R9: With `preload_en` at 0, a write takes effect in the active compare register at the clock edge of the write.
- R10: `match_flag` is set at the edge after a cycle in which the counter equals the active compare value. It is cleared by `flag_clr` in a cycle with no match; a match has priority over `flag_clr`.
- R11: While `rst_n` is low, the reference, the clear hold, the flag and the compare registers are 0, and so `ch_out` is 0 with polarity 0.
- R12: Mode logic is registered: the reference changes at the clock edge that follows the counter value causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | CNT_W | Counter value from the timer |
| update | input | 1 | Update event pulse from the timer |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value to write |
| preload_en | input | 1 | 1: compare write goes through shadow register |
| mode | input | 3 | Compare mode code 0..7 |
| polarity | input | 1 | 1 inverts the reference on the pin |
| out_en | input | 1 | Output gate |
| clr_en | input | 1 | Enables the external clear |
| clr_in | input | 1 | External clear level |
| flag_clr | input | 1 | Clears the match flag |
| ch_out | output | 1 | Channel output |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
A vector table steps through every mode with the compare value fixed, using counter values just below, at and above it. These vectors show whether set, reset and toggle act only on equality, whether frozen really holds, and whether the two PWM codes split at the strict less-than boundary. Polarity and the enable gate are tried against a known reference. Directed sequences then show the difference between a preloaded write, which has no effect until an update, and a direct write, which acts at once. They show the clear latch holding through cycles and releasing only on update, its exemption in forced mode, and the flag's set-over-clear priority.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN   = 3'd0,
    OCM_SET_HIT  = 3'd1,
    OCM_CLR_HIT  = 3'd2,
    OCM_TOGGLE   = 3'd3,
    OCM_FORCE_LO = 3'd4,
    OCM_FORCE_HI = 3'd5,
    OCM_PWM_LT   = 3'd6,
    OCM_PWM_GE   = 3'd7
  } oc_mode_e;

  function automatic logic is_forced(oc_mode_e m);
    return (m == OCM_FORCE_LO) || (m == OCM_FORCE_HI);
  endfunction
endpackage

// File: rtl/oc_cmp_reg.sv
module oc_cmp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         preload_en,
  input  logic         update,
  output logic [W-1:0] cmp_act
);
  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] act_q, act_d;
  logic         shadow_ce, act_ce;

  always_comb begin
    shadow_ce = we;
    shadow_d  = wdata;
    act_ce    = 1'b0;
    act_d     = act_q;
    if (!preload_en && we) begin
      act_ce = 1'b1;
      act_d  = wdata;
    end else if (preload_en && update) begin
      act_ce = 1'b1;
      act_d  = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (shadow_ce) shadow_q <= shadow_d;
      if (act_ce)    act_q    <= act_d;
    end
  end

  assign cmp_act = act_q;

  // R8: in buffered mode the active value only moves on update
  a_r8_preload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !update) |=> $stable(cmp_act));
  // R9: direct write reaches the active register at once
  a_r9_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && we) |=> (cmp_act == $past(wdata)));
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  oc_mode_e     mode,
  input  logic         clr_en,
  input  logic         clr_in,
  input  logic         update,
  output logic         ref_eff
);
  logic hit, below;
  logic ref_q, ref_d;
  logic hold_q, hold_d;

  assign hit   = (cnt == cmp);
  assign below = (cnt < cmp);

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OCM_FROZEN:   ref_d = ref_q;
      OCM_SET_HIT:  if (hit) ref_d = 1'b1;
      OCM_CLR_HIT:  if (hit) ref_d = 1'b0;
      OCM_TOGGLE:   if (hit) ref_d = ~ref_q;
      OCM_FORCE_LO: ref_d = 1'b0;
      OCM_FORCE_HI: ref_d = 1'b1;
      OCM_PWM_LT:   ref_d = below;
      OCM_PWM_GE:   ref_d = ~below;
      default:      ref_d = ref_q;
    endcase
  end

  always_comb begin
    hold_d = hold_q;
    if (clr_en && clr_in) hold_d = 1'b1;
    else if (update)      hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      hold_q <= hold_d;
    end
  end

  assign ref_eff = (hold_q && !is_forced(mode)) ? 1'b0 : ref_q;

  // R1: frozen mode never moves the reference
  a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OCM_FROZEN) |=> $stable(ref_q));
  // R4: forced high sets the reference on the next edge
  a_r4_force_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OCM_FORCE_HI) |=> ref_q);
  // R6: enabled clear is latched
  a_r6_clear_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_in) |=> hold_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             update,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             preload_en,
  input  logic [2:0]       mode,
  input  logic             polarity,
  input  logic             out_en,
  input  logic             clr_en,
  input  logic             clr_in,
  input  logic             flag_clr,
  output logic             ch_out,
  output logic             match_flag
);
  logic [CNT_W-1:0] cmp_act;
  logic             ref_lvl;
  logic             flag_q, flag_d;
  oc_mode_e         mode_e;

  assign mode_e = oc_mode_e'(mode);

  oc_cmp_reg #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .we(cmp_we), .wdata(cmp_wdata),
    .preload_en(preload_en), .update(update), .cmp_act(cmp_act)
  );

  oc_ref_gen #(.W(CNT_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp_act), .mode(mode_e),
    .clr_en(clr_en), .clr_in(clr_in), .update(update), .ref_eff(ref_lvl)
  );

  always_comb begin
    flag_d = flag_q;
    if (cnt == cmp_act) flag_d = 1'b1;
    else if (flag_clr)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign match_flag = flag_q;
  assign ch_out     = out_en ? (ref_lvl ^ polarity) : 1'b0;

  // R10: a match always leaves the flag set
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cmp_act) |=> match_flag);
endmodule

// File: tb/oc_channel_test.sv
module oc_channel_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt;
  logic         update, cmp_we, preload_en, polarity, out_en;
  logic         clr_en, clr_in, flag_clr;
  logic [W-1:0] cmp_wdata;
  logic [2:0]   mode;
  logic         ch_out, match_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  oc_channel #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .update(update), .cmp_we(cmp_we),
    .cmp_wdata(cmp_wdata), .preload_en(preload_en), .mode(mode),
    .polarity(polarity), .out_en(out_en), .clr_en(clr_en), .clr_in(clr_in),
    .flag_clr(flag_clr), .ch_out(ch_out), .match_flag(match_flag)
  );

  // {mode, cnt, polarity, out_en, expected ch_out}; compare value 10
  localparam logic [21:0] VEC [18] = '{
    {3'd5, 16'd3,  1'b0, 1'b1, 1'b1},  // R4 force high
    {3'd4, 16'd10, 1'b0, 1'b1, 1'b0},  // R4 force low
    {3'd0, 16'd10, 1'b0, 1'b1, 1'b0},  // R1 frozen on match
    {3'd1, 16'd9,  1'b0, 1'b1, 1'b0},  // R2 no match
    {3'd1, 16'd10, 1'b0, 1'b1, 1'b1},  // R2 set on match
    {3'd2, 16'd11, 1'b0, 1'b1, 1'b1},  // R2 hold
    {3'd2, 16'd10, 1'b0, 1'b1, 1'b0},  // R2 clear on match
    {3'd3, 16'd10, 1'b0, 1'b1, 1'b1},  // R3 toggle
    {3'd3, 16'd10, 1'b0, 1'b1, 1'b0},  // R3 toggle again
    {3'd3, 16'd5,  1'b0, 1'b1, 1'b0},  // R3 no match
    {3'd6, 16'd9,  1'b0, 1'b1, 1'b1},  // R5 below
    {3'd6, 16'd10, 1'b0, 1'b1, 1'b0},  // R5 equal
    {3'd7, 16'd9,  1'b0, 1'b1, 1'b0},  // R5 inverse below
    {3'd7, 16'd10, 1'b0, 1'b1, 1'b1},  // R5 inverse equal
    {3'd0, 16'd10, 1'b0, 1'b1, 1'b1},  // R1 frozen holds 1
    {3'd6, 16'd0,  1'b1, 1'b1, 1'b0},  // R7 active low
    {3'd6, 16'd0,  1'b1, 1'b0, 1'b0},  // R7 gated off
    {3'd7, 16'd0,  1'b1, 1'b1, 1'b1}   // R7 active low, ref 0
  };

  task automatic check(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt = '0; update = 0; cmp_we = 0; cmp_wdata = '0;
    preload_en = 0; mode = 3'd0; polarity = 0; out_en = 1;
    clr_en = 0; clr_in = 0; flag_clr = 0;
    tick(); tick();
    check("R11 reset out", ch_out, 1'b0);
    check("R11 reset flag", match_flag, 1'b0);
    #1 rst_n = 1'b1;
    cnt = 16'd3; cmp_we = 1; cmp_wdata = 16'd10;
    tick();
    cmp_we = 0;
    for (int i = 0; i < 18; i++) begin
      mode = VEC[i][21:19]; cnt = VEC[i][18:3];
      polarity = VEC[i][2]; out_en = VEC[i][1];
      tick();
      check($sformatf("R12 vector %0d", i), ch_out, VEC[i][0]);
    end
    polarity = 0; out_en = 1;

    // R10 match flag
    check("R10 flag set", match_flag, 1'b1);
    cnt = 16'd5; flag_clr = 1; tick();
    check("R10 flag cleared", match_flag, 1'b0);
    cnt = 16'd10; tick();
    check("R10 match beats clear", match_flag, 1'b1);
    flag_clr = 0; cnt = 16'd5;

    // R8 preload
    mode = 3'd6; preload_en = 1; cmp_we = 1; cmp_wdata = 16'd20; cnt = 16'd15;
    tick();
    cmp_we = 0;
    check("R8 write buffered", ch_out, 1'b0);
    update = 1; tick();
    update = 0;
    check("R8 update edge uses old value", ch_out, 1'b0);
    tick();
    check("R8 new value after update", ch_out, 1'b1);

    // R9 direct write
    preload_en = 0; cmp_we = 1; cmp_wdata = 16'd12; cnt = 16'd11; tick();
    cmp_we = 0;
    cnt = 16'd12; tick();
    check("R9 direct write active", ch_out, 1'b0);
    cnt = 16'd11; tick();
    check("R9 below new value", ch_out, 1'b1);

    // R6 clear
    clr_en = 1; cnt = 16'd0; tick();
    clr_in = 1; tick();
    check("R6 clear forces off", ch_out, 1'b0);
    clr_in = 0; tick(); tick();
    check("R6 clear held", ch_out, 1'b0);
    update = 1; tick();
    update = 0;
    check("R6 released by update", ch_out, 1'b1);
    mode = 3'd5; clr_in = 1; tick();
    clr_in = 0; tick();
    check("R6 forced mode exempt", ch_out, 1'b1);
    mode = 3'd6; update = 1; tick();
    update = 0; clr_en = 0; clr_in = 1; tick(); tick();
    check("R6 clear disabled ignored", ch_out, 1'b1);
    clr_in = 0;

    // R11 reset mid-run
    rst_n = 1'b0; #1;
    check("R11 async reset out", ch_out, 1'b0);
    check("R11 async reset flag", match_flag, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule